// File: doc/BRIEF.md
# Edge-Selectable Timer Capture Channel

This block timestamps events on an external input. A free-running counter, advanced by an enable tick, runs inside the block. When the chosen edge appears on the input, the block copies the counter into a capture register and raises a sticky event flag. An interrupt request follows the flag when interrupts are enabled. Software must clear the flag itself.

The raw input first passes through a synchronizer. A qualifier then accepts a new level only after that level has been seen on consecutive clocks for the minimum width. Edges are taken from the qualified level only, so glitches shorter than that width never cause a capture. A small write port loads the control bits and clears the flag. The qualified level is visible on an output, so software can tell which edge fired when both edges are enabled.

Top module: `timer_capture_chan`

## Requirements
- R1: `timerVal` increases by 1 on every clock edge where `tickEn` is 1. It keeps its value when `tickEn` is 0, and it wraps from 0xFFFF to 0x0000.
- R2: On a capture, `{capHi, capLo}` takes the value `timerVal` had in the cycle the qualified edge was detected. A pin change driven before clock edge k is detected at edge k+3.
- R3: The control register is address 0. Writing it loads bit0 = rising enable, bit1 = falling enable and bit2 = interrupt enable, and `ctrlRd` reads back the same bits. Rising alone captures only low-to-high edges, falling alone captures only high-to-low edges, and both together capture either edge.
- R4: With both edge enables at 0, no edge causes a capture or sets the flag.
- R5: Every capture sets `capFlag` to 1.
- R6: `irqReq` is 1 exactly when `capFlag` is 1 and the interrupt enable is 1.
- R7: `capFlag` is sticky. Only a write to address 1 with bit0 = 0 clears it. A write to address 1 with bit0 = 1 has no effect.
- R8: A capture in the same cycle as a flag clear wins, so the flag stays 1. A capture while the flag is already 1 still overwrites the capture register.
- R9: An input level counts only after it has been stable for 2 clocks. A 1-clock pulse causes no capture. A 2-clock pulse does cause one.
- R10: `pinLevel` shows the qualified input level, so software can read the edge direction after a capture in both-edge mode.
- R11: Reset (active-low `rstN`) clears the counter, the capture register, the flag and all three control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter advance enable |
| pinIn | input | 1 | Raw asynchronous event input |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 flag |
| wrData | input | 3 | Write data |
| ctrlRd | output | 3 | Control bits {irq enable, falling, rising} |
| timerVal | output | 16 | Current counter value |
| capLo | output | 8 | Capture register low byte |
| capHi | output | 8 | Capture register high byte |
| capFlag | output | 1 | Sticky capture flag |
| irqReq | output | 1 | Interrupt request |
| pinLevel | output | 1 | Qualified input level |

## Verification
The bench sends single-cycle glitches and two-cycle pulses. A qualifier that is one stage short would capture the glitch, and one that is one stage long would miss the pulse. It lines up a flag clear with the cycle of a capture, where a design with the wrong priority drops the event. It also checks the captured value against the counter in the detection cycle, so a design that samples one cycle early or late shows an off-by-one timestamp. It also runs the counter through its wrap, drives every edge-select encoding including the disabled one, and confirms that the flag survives interrupt disable and writes of 1.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic count;
  } dpStrobe_t;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_FLAG = 1;
  localparam int CTRL_W    = 3;
endpackage

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_LEN    = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] wrData,
  output dpStrobe_t         stb,
  output logic              posEn,
  output logic              negEn,
  output logic              irqEn,
  output logic              capFlag,
  output logic              irqReq,
  output logic              pinLevel
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [QUAL_LEN-2:0]    histQ;
  logic [QUAL_LEN-1:0]    window;
  logic                   filtQ;
  logic                   riseDet;
  logic                   fallDet;
  logic                   capNow;
  logic                   ctrlWr;
  logic                   flagClr;

  // input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  // sample history for the stable-width qualifier
  generate
    if (QUAL_LEN > 2) begin : gLongHist
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) histQ <= '0;
        else       histQ <= {histQ[QUAL_LEN-3:0], syncOut};
      end
    end else begin : gShortHist
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) histQ <= '0;
        else       histQ <= syncOut;
      end
    end
  endgenerate

  assign window  = {histQ, syncOut};
  assign riseDet = (&window) && !filtQ;
  assign fallDet = !(|window) && filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        filtQ <= 1'b0;
    else if (riseDet) filtQ <= 1'b1;
    else if (fallDet) filtQ <= 1'b0;
  end

  assign capNow  = (riseDet && posEn) || (fallDet && negEn);
  assign ctrlWr  = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));
  assign flagClr = wrEn && (wrAddr == ADDR_W'(ADDR_FLAG)) && !wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posEn <= 1'b0;
      negEn <= 1'b0;
      irqEn <= 1'b0;
    end else if (ctrlWr) begin
      posEn <= wrData[0];
      negEn <= wrData[1];
      irqEn <= wrData[2];
    end
  end

  // capture has priority over a software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        capFlag <= 1'b0;
    else if (capNow)  capFlag <= 1'b1;
    else if (flagClr) capFlag <= 1'b0;
  end

  assign irqReq      = capFlag && irqEn;
  assign pinLevel    = filtQ;
  assign stb.capture = capNow;
  assign stb.count   = tickEn;
endmodule

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  output logic [CNT_W-1:0] timerVal,
  output logic [CNT_W-1:0] capVal
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] capQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntQ <= '0;
    else if (stb.count) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            capQ <= '0;
    else if (stb.capture) capQ <= cntQ;
  end

  assign timerVal = cntQ;
  assign capVal   = capQ;
endmodule

// File: rtl/timer_capture_chan.sv
module timer_capture_chan
  import tcap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_LEN    = 2,
  localparam int CNT_W      = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              pinIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlRd,
  output logic [CNT_W-1:0]  timerVal,
  output logic [DATA_W-1:0] capLo,
  output logic [DATA_W-1:0] capHi,
  output logic              capFlag,
  output logic              irqReq,
  output logic              pinLevel
);
  dpStrobe_t        stb;
  logic             posEn;
  logic             negEn;
  logic             irqEn;
  logic [CNT_W-1:0] capVal;

  tcap_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_LEN   (QUAL_LEN),
    .ADDR_W     (ADDR_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .tickEn  (tickEn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .stb     (stb),
    .posEn   (posEn),
    .negEn   (negEn),
    .irqEn   (irqEn),
    .capFlag (capFlag),
    .irqReq  (irqReq),
    .pinLevel(pinLevel)
  );

  tcap_datapath #(.CNT_W(CNT_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .timerVal(timerVal),
    .capVal  (capVal)
  );

  assign ctrlRd = {irqEn, negEn, posEn};
  assign capLo  = capVal[DATA_W-1:0];
  assign capHi  = capVal[CNT_W-1:DATA_W];
endmodule

// File: rtl/tcap_checker.sv
module tcap_checker
  import tcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CTRL_W-1:0] wrData,
  input logic [CNT_W-1:0]  timerVal,
  input logic [DATA_W-1:0] capLo,
  input logic [DATA_W-1:0] capHi,
  input logic              capFlag,
  input dpStrobe_t         stb,
  input logic              posEn,
  input logic              negEn
);
  logic clrReq;
  assign clrReq = wrEn && (wrAddr == ADDR_W'(ADDR_FLAG)) && !wrData[0];

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && timerVal == '1) |=> (timerVal == '0));

  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(timerVal));

  a_r2_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> ({capHi, capLo} == $past(timerVal)));

  a_r4_no_enable: assert property (@(posedge clk) disable iff (!rstN)
    (!posEn && !negEn) |-> !stb.capture);

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> capFlag);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !clrReq) |=> capFlag);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!capFlag && !stb.capture) |=> !capFlag);
endmodule

bind timer_capture_chan tcap_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .timerVal(timerVal),
  .capLo   (capLo),
  .capHi   (capHi),
  .capFlag (capFlag),
  .stb     (stb),
  .posEn   (posEn),
  .negEn   (negEn)
);

// File: tb/timer_capture_chan_test.sv
module timer_capture_chan_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        pinIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [2:0]  wrData = 3'd0;
  logic [2:0]  ctrlRd;
  logic [15:0] timerVal;
  logic [7:0]  capLo;
  logic [7:0]  capHi;
  logic        capFlag;
  logic        irqReq;
  logic        pinLevel;

  int total = 0;
  int bad = 0;
  logic [15:0] mdl;

  typedef struct packed {
    logic [1:0] mode;
    logic       lvl;
    logic       exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b01, 1'b1, 1'b1},
    '{2'b01, 1'b0, 1'b0},
    '{2'b10, 1'b1, 1'b0},
    '{2'b10, 1'b0, 1'b1},
    '{2'b11, 1'b1, 1'b1},
    '{2'b11, 1'b0, 1'b1},
    '{2'b00, 1'b1, 1'b0},
    '{2'b00, 1'b0, 1'b0}
  };

  timer_capture_chan uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .pinIn(pinIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .ctrlRd(ctrlRd),
    .timerVal(timerVal), .capLo(capLo), .capHi(capHi),
    .capFlag(capFlag), .irqReq(irqReq), .pinLevel(pinLevel)
  );

  always #10 clk = ~clk;

  // reference counter from R1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       mdl <= 16'd0;
    else if (tickEn) mdl <= mdl + 16'd1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [2:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // drive a level at a negedge, return counter value in the detection cycle
  task automatic applyLevel(input logic lvl, output logic [15:0] e);
    pinIn = lvl;
    repeat (3) @(negedge clk);
    e = mdl;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] e;
    logic [15:0] e2;
    logic [15:0] t;
    tickEn = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 timer", timerVal, 0);
    chk("R11 cap", {capHi, capLo}, 0);
    chk("R11 flag", capFlag, 0);
    chk("R11 ctrl", ctrlRd, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 count", timerVal, mdl);

    // vector walk over edge-select modes (R3, R4, R5, R6, R2, R10)
    for (int i = 0; i < 8; i++) begin
      wrReg(2'd0, {1'b1, VECS[i].mode});
      chk("R3 ctrlRd", ctrlRd, {1'b1, VECS[i].mode});
      wrReg(2'd1, 3'b000);
      applyLevel(VECS[i].lvl, e);
      if (VECS[i].mode == 2'b00) chk("R4 flag", capFlag, 0);
      else                       chk("R3 R5 flag", capFlag, VECS[i].exp);
      chk("R6 irq", irqReq, VECS[i].exp);
      if (VECS[i].exp) chk("R2 value", {capHi, capLo}, e);
      if (VECS[i].mode == 2'b11) chk("R10 level", pinLevel, VECS[i].lvl);
    end

    // R9 one-cycle glitch ignored
    wrReg(2'd0, 3'b111);
    wrReg(2'd1, 3'b000);
    pinIn = 1'b1;
    @(negedge clk);
    pinIn = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 glitch flag", capFlag, 0);
    chk("R9 glitch level", pinLevel, 0);

    // R9 two-cycle pulse captured, then its falling edge (R3 both)
    pinIn = 1'b1;
    repeat (2) @(negedge clk);
    pinIn = 1'b0;
    @(negedge clk);
    e = mdl;
    @(negedge clk);
    chk("R9 pulse flag", capFlag, 1);
    chk("R9 pulse value", {capHi, capLo}, e);
    @(negedge clk);
    e2 = mdl;
    @(negedge clk);
    chk("R3 fall value", {capHi, capLo}, e2);

    // R7 sticky flag
    repeat (10) @(negedge clk);
    chk("R7 sticky", capFlag, 1);
    wrReg(2'd1, 3'b001);
    chk("R7 write one", capFlag, 1);
    wrReg(2'd0, 3'b011);
    chk("R6 irq off", irqReq, 0);
    chk("R7 kept w/o irq", capFlag, 1);
    wrReg(2'd1, 3'b000);
    chk("R7 clear", capFlag, 0);
    wrReg(2'd1, 3'b001);
    chk("R7 write one idle", capFlag, 0);

    // R8 overwrite while flag set
    applyLevel(1'b1, e);
    chk("R8 first", {capHi, capLo}, e);
    repeat (3) @(negedge clk);
    applyLevel(1'b0, e2);
    chk("R8 overwrite", {capHi, capLo}, e2);
    chk("R8 differ", (e2 != e), 1);

    // R8 capture beats clear in the same cycle
    pinIn = 1'b1;
    repeat (3) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd1; wrData = 3'b000;
    e = mdl;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R8 collide flag", capFlag, 1);
    chk("R8 collide value", {capHi, capLo}, e);

    // R1 hold
    tickEn = 1'b0;
    t = timerVal;
    repeat (5) @(negedge clk);
    chk("R1 hold", timerVal, t);
    tickEn = 1'b1;

    // R1 wrap
    for (int n = 0; n < 70000 && mdl != 16'hFFFF; n++) @(negedge clk);
    chk("R1 max", timerVal, 16'hFFFF);
    @(negedge clk);
    chk("R1 wrap", timerVal, 0);

    // R11 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 timer again", timerVal, 0);
    chk("R11 cap again", {capHi, capLo}, 0);
    chk("R11 flag again", capFlag, 0);
    chk("R11 ctrl again", ctrlRd, 0);
    rstN = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule